// File: doc/BRIEF.md
# ZigZag Variable-Length Integer Encoder

This block turns a stream of 64-bit signed integers into a compact byte stream. Each integer first goes through a sign-interleaving map, so that values close to zero become small unsigned numbers whatever their sign. The mapped value is then cut into 7-bit groups, and the block sends only as many groups as the value needs, one byte per group. The upper bit of each byte says whether another byte follows.

Integers arrive on a valid/ready input. Bytes leave on a valid/ready output that carries a flag on the final byte of each integer. The block holds one integer at a time. It sends one byte in every cycle in which the consumer is ready, and it takes the next integer only after the final byte of the current one has been accepted. Reset is asserted asynchronously and released synchronously inside the block.

Top module: `zz_varint_enc`

## Requirements
- R1: An input n is mapped to the unsigned value (n shifted left by one) XOR (n shifted right arithmetically by 63). This sends 0, -1, 1, -2, 2 to 0, 1, 2, 3, 4.
- R2: Bits 6..0 of each output byte hold one 7-bit group of the mapped value. The least significant group goes out first.
- R3: Bit 7 of the output byte is 1 on every byte of an integer except its final one. On the final byte, bit 7 is 0 and `out_last` is 1.
- R4: Any input from -64 to 63 produces exactly one byte.
- R5: The number of bytes is the smallest count of 7-bit groups that holds the mapped value, with a minimum of one. The largest mapped values produce 10 bytes.
- R6: While `out_valid` is high and `out_ready` is low, the output byte and `out_last` stay unchanged. While `out_ready` is high, one byte is accepted per cycle.
- R7: `in_ready` is high only when no byte of an earlier integer is pending. The first byte of an accepted integer is presented in the cycle after acceptance.
- R8: After reset, `out_valid` is low and `in_ready` becomes high once the internal reset release completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| in_valid | input | 1 | Input integer is valid |
| in_ready | output | 1 | Encoder can take an integer |
| in_data | input | 64 | Signed integer to encode |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Consumer takes the byte |
| out_byte | output | 8 | Encoded byte: continuation flag in bit 7, payload in bits 6..0 |
| out_last | output | 1 | Final byte of the current integer |

## Verification
The bench drives zero and small values of both signs. These expose a wrong sign map or a sign-extension fault, because the ±1 and -64/63 edges differ in a single bit. Values just past a group boundary, such as 64, -65 and 8192, tell an off-by-one length from a correct one. Extreme values such as the largest and smallest 64-bit integers test the ten-byte case and the partial top group. Random wide values are sent under three consumer patterns (always ready, mostly ready, alternating) to separate correct hold behaviour from dropped or repeated bytes.

// File: rtl/zz_pkg.sv
package zz_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EMIT = 1'b1
  } zz_state_t;
endpackage

// File: rtl/zz_rst_sync.sv
module zz_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/zz_map.sv
module zz_map #(
  parameter int W = 64
) (
  input  logic [W-1:0] sval,
  output logic [W-1:0] uval
);
  logic [W-1:0] sign_fill;

  always_comb begin
    sign_fill = {W{sval[W-1]}};
    uval      = {sval[W-2:0], 1'b0} ^ sign_fill;
  end
endmodule

// File: rtl/zz_len.sv
module zz_len #(
  parameter int W  = 64,
  parameter int GB = 7,
  localparam int NG = (W + GB - 1) / GB,
  localparam int CW = $clog2(NG + 1)
) (
  input  logic [W-1:0]  val,
  output logic [CW-1:0] nbytes
);
  logic [NG-1:0] grp_nz;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_nz[g] = |val[W-1:g*GB];
  end

  always_comb begin
    nbytes = CW'(1);
    for (int g = 0; g < NG; g++) begin
      if (grp_nz[g]) nbytes = CW'(g + 1);
    end
  end
endmodule

// File: rtl/zz_ser.sv
module zz_ser
  import zz_pkg::*;
#(
  parameter int W  = 64,
  parameter int GB = 7,
  localparam int NG = (W + GB - 1) / GB,
  localparam int CW = $clog2(NG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  load_val,
  input  logic [CW-1:0] load_len,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [GB:0]   out_byte,
  output logic          out_last,
  output logic          idle
);
  zz_state_t     st_q, st_d;
  logic [W-1:0]  sh_q, sh_d;
  logic [CW-1:0] rem_q, rem_d;
  logic          load_en, shift_en, final_byte;

  assign final_byte = (rem_q == CW'(1));
  assign load_en    = (st_q == ST_IDLE) && load;
  assign shift_en   = (st_q == ST_EMIT) && out_ready;

  always_comb begin
    st_d  = st_q;
    sh_d  = sh_q;
    rem_d = rem_q;
    if (load_en) begin
      st_d  = ST_EMIT;
      sh_d  = load_val;
      rem_d = load_len;
    end else if (shift_en) begin
      sh_d  = sh_q >> GB;
      rem_d = rem_q - CW'(1);
      if (final_byte) st_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      sh_q  <= '0;
      rem_q <= '0;
    end else if (load_en || shift_en) begin
      st_q  <= st_d;
      sh_q  <= sh_d;
      rem_q <= rem_d;
    end
  end

  assign out_valid = (st_q == ST_EMIT);
  assign out_last  = out_valid && final_byte;
  assign out_byte  = {~final_byte, sh_q[GB-1:0]};
  assign idle      = (st_q == ST_IDLE);
endmodule

// File: rtl/zz_varint_enc.sv
module zz_varint_enc #(
  parameter int W  = 64,
  parameter int GB = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [GB:0]  out_byte,
  output logic         out_last
);
  localparam int NG = (W + GB - 1) / GB;
  localparam int CW = $clog2(NG + 1);

  logic          srst_n;
  logic [W-1:0]  mapped;
  logic [CW-1:0] glen;
  logic          ser_idle;
  logic          take;

  zz_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  zz_map #(.W(W)) u_map (
    .sval (in_data),
    .uval (mapped)
  );

  zz_len #(.W(W), .GB(GB)) u_len (
    .val    (mapped),
    .nbytes (glen)
  );

  assign in_ready = ser_idle && srst_n;
  assign take     = in_valid && in_ready;

  zz_ser #(.W(W), .GB(GB)) u_ser (
    .clk       (clk),
    .rst_n     (srst_n),
    .load      (take),
    .load_val  (mapped),
    .load_len  (glen),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .out_last  (out_last),
    .idle      (ser_idle)
  );
endmodule

// File: rtl/zz_varint_chk.sv
module zz_varint_chk #(
  parameter int W  = 64,
  parameter int GB = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_data,
  input logic         out_valid,
  input logic         out_ready,
  input logic [GB:0]  out_byte,
  input logic         out_last
);
  localparam int NG = (W + GB - 1) / GB;
  localparam int KW = $clog2(NG + 2);

  logic [KW-1:0] sent_q;
  logic          small_in;

  assign small_in = (in_data[W-1:GB-1] == '0) || (in_data[W-1:GB-1] == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 sent_q <= '0;
    else if (out_valid && out_ready && out_last) sent_q <= '0;
    else if (out_valid && out_ready)             sent_q <= sent_q + KW'(1);
  end

  // R3: flag bit follows the last marker
  a_r3_flag_last: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_byte[GB] == !out_last));

  // R4: small inputs give a single byte
  a_r4_single: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && small_in) |=> (out_valid && out_last));

  // R5: never more than NG bytes per integer
  a_r5_max_len: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (sent_q < KW'(NG)));

  // R6: output holds under backpressure
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last)));

  // R7: no new integer while bytes pend
  a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  // R7: first byte follows acceptance
  a_r7_first: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

bind zz_varint_enc zz_varint_chk #(.W(W), .GB(GB)) u_chk (.*);

// File: tb/test_zz_varint_enc.sv
module test_zz_varint_enc;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  out_byte;
  logic        out_last;

  int checks = 0;
  int errors = 0;
  logic [8:0] exp_q[$];
  int         len_q[$];
  int         rmode = 0;
  int         cyc = 0;
  bit         mon_en = 0;
  bit         hold = 0;
  logic [8:0] held;
  int         nbytes = 0;

  zz_varint_enc i_zz_varint_enc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .out_last(out_last)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  // reference model: zigzag then 7-bit groups, low group first
  task automatic send(input logic [63:0] v);
    logic [63:0] u;
    int n;
    u = {v[62:0], 1'b0} ^ {64{v[63]}};
    n = 0;
    do begin
      logic [6:0] g;
      g = u[6:0];
      u = u >> 7;
      exp_q.push_back({(u == 0), (u != 0), g});
      n++;
    end while (u != 0);
    len_q.push_back(n);
    in_data  = v;
    in_valid = 1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk);
    #2 in_valid = 0;
    @(negedge clk);
    check(out_valid === 1'b1, "R7 first byte after accept", 64'(out_valid), 64'd1);
  endtask

  always @(posedge clk) begin
    #2;
    cyc++;
    case (rmode)
      0:       out_ready = 1'b1;
      1:       out_ready = (cyc % 3) != 0;
      default: out_ready = cyc[0];
    endcase
  end

  always @(negedge clk) begin
    if (mon_en) begin
      if (in_ready && out_valid)
        check(1'b0, "R7 in_ready while byte pending", 64'd1, 64'd0);
      if (hold)
        check(out_valid && ({out_last, out_byte} == held), "R6 hold under stall",
              64'({out_valid, out_last, out_byte}), 64'({1'b1, held}));
      hold = out_valid && !out_ready;
      held = {out_last, out_byte};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected byte", 64'({out_last, out_byte}), 64'd0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check({out_last, out_byte} == e, "R1 R2 R3 byte value",
                64'({out_last, out_byte}), 64'(e));
        end
        nbytes++;
        if (out_last) begin
          int el;
          el = (len_q.size() != 0) ? len_q.pop_front() : 0;
          if (el == 1) check(nbytes == el, "R4 single byte length", 64'(nbytes), 64'(el));
          else         check(nbytes == el, "R5 byte count", 64'(nbytes), 64'(el));
          nbytes = 0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'(cyc), 64'd0);
    summary();
  end

  initial begin
    rst_n = 0;
    in_valid = 0;
    in_data = '0;
    out_ready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b0, "R8 out_valid low in reset", 64'(out_valid), 64'd0);
    check(in_ready === 1'b0, "R8 in_ready low in reset", 64'(in_ready), 64'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(in_ready === 1'b1, "R8 in_ready after release", 64'(in_ready), 64'd1);
    check(out_valid === 1'b0, "R8 out_valid idle after release", 64'(out_valid), 64'd0);
    mon_en = 1;
    @(posedge clk);
    #2;
    for (int m = 0; m < 3; m++) begin
      rmode = m;
      send(64'd0);
      send(-64'sd1);
      send(64'd1);
      send(-64'sd2);
      send(64'd2);
      send(64'd63);
      send(-64'sd64);
      send(64'd64);
      send(-64'sd65);
      send(64'd300);
      send(64'd8192);
      send(64'h7FFF_FFFF_FFFF_FFFF);
      send(64'h8000_0000_0000_0000);
      send(64'h4000_0000_0000_0000);
      send(64'hC000_0000_0000_0000);
      for (int k = 0; k < 20; k++) send({$urandom, $urandom} >> (k * 3));
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R7 idle after drain",
          64'({out_valid, in_ready}), 64'b01);
    summary();
  end
endmodule